// File: doc/BRIEF.md
# NAND Page-Open Read Sequencer

This block walks a NAND flash device through the cycle sequence that opens one page for reading. It then asks for that page to be moved into the controller's buffers, one 512-byte chunk at a time. A page number goes in with a start pulse. The block issues each step, one at a time, to a flash pin engine that sits beside it. Each step is a command byte, an address byte or a buffer-fill request. The block holds the step on its outputs until the engine answers with a one-cycle ready pulse.

Two parameters shape the sequence: the page size and the device size. Pages larger than 512 bytes get a second column byte and a closing read-start command. The number of row bytes is fixed by the page count of the device. When every buffer fill has been acknowledged, the block raises done for one cycle and returns to idle. Pin timing, error correction and moving the data out are handled elsewhere.

Top module: `nand_rd_seq`

## Requirements
- R1: A start pulse is accepted only while busy is low. Busy goes high in the cycle after an accepted start and stays high through the single cycle in which done is high; it falls in the cycle after that. A start pulse seen while busy is high changes nothing.
- R2: Each step appears with reqStrobe high for exactly one cycle. reqKind, reqByte and bufIdx are held until the step is acknowledged. A step is acknowledged by a stepRdy pulse sampled in any later cycle of the wait. The next step's strobe comes in the cycle after that acknowledgement. A stepRdy pulse sampled while idle, or in the same cycle as a strobe, is ignored.
- R3: reqKind encodes command = 0, address byte = 1, buffer fill = 2. The first step of every run is a command with byte 0x00.
- R4: One address byte of 0x00 follows the first command. A second 0x00 address byte follows it only when PAGE_BYTES is larger than 512.
- R5: Row address bytes follow the column bytes, least significant byte of the page number first. Their count is the number of bytes needed to hold PAGE_COUNT-1, and is at least one. PAGE_COUNT is DEVICE_BYTES/PAGE_BYTES.
- R6: When the page number is greater than PAGE_COUNT, no row bytes are sent. A page number equal to PAGE_COUNT still sends them.
- R7: A trailing 0x00 address byte always follows the row phase.
- R8: When PAGE_BYTES is larger than 512, a command with byte 0x30 follows the trailing address byte. No such command is issued otherwise.
- R9: PAGE_BYTES/512 buffer-fill steps come last, with bufIdx counting up from 0. Done is raised in the cycle after the last fill is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to open a page |
| pageAddr | input | PAGE_W | Page number, captured with an accepted start |
| stepRdy | input | 1 | One-cycle acknowledgement of the outstanding step |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the run completes |
| reqStrobe | output | 1 | One-cycle pulse announcing a new step |
| reqKind | output | 2 | Step type: 0 command, 1 address, 2 buffer fill |
| reqByte | output | 8 | Command or address byte of the step |
| bufIdx | output | FILL_W | Buffer chunk index for fill steps |

## Verification
The bench drives two builds side by side: a 2048-byte page and a 512-byte page. Each build's step stream is compared against a model. Page numbers just below, exactly at and just above the page count are all exercised. A design that used the wrong comparison at the page limit would drop the row bytes, or keep them. A design that miscounted row bytes would shift every later step. Stray ready pulses are sent while idle and in the strobe cycle itself. A design that accepted either would skip a step or emit a step with no run. A second start pulse in mid-run checks that the captured page and the sequence survive it. A start issued right after a run ends checks that the idle state is reached cleanly.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_FILL = 2'd2
  } stepKind_e;

  typedef enum logic [1:0] {
    SEL_ZERO,
    SEL_ROW,
    SEL_RDSTART
  } byteSel_e;

  typedef enum logic [2:0] {
    PH_READ0,
    PH_COL0,
    PH_COL1,
    PH_ROW,
    PH_TAIL,
    PH_RDSTART,
    PH_FILL
  } phase_e;

  // strobes from control into the datapath
  typedef struct packed {
    logic     loadPage;
    logic     clearIdx;
    logic     stepRow;
    logic     stepFill;
    byteSel_e byteSel;
  } dpCtl_t;

  localparam logic [7:0] OP_READ0     = 8'h00;
  localparam logic [7:0] OP_READSTART = 8'h30;
  localparam int         CHUNK_BYTES  = 512;

  // bytes needed to carry the highest page number, never fewer than one
  function automatic int rowBytesFor(longint lastPage);
    int     n;
    longint v;
    n = 1;
    v = lastPage >> 8;
    while (v != 0) begin
      n = n + 1;
      v = v >> 8;
    end
    return n;
  endfunction

  function automatic int widthFor(longint n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/nand_rd_dpath.sv
module nand_rd_dpath
  import nand_rd_pkg::*;
#(
  parameter int     PAGE_W     = 17,
  parameter int     ROW_BYTES  = 2,
  parameter int     ROW_W      = 1,
  parameter int     FILLS      = 4,
  parameter int     FILL_W     = 2,
  parameter longint PAGE_COUNT = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [PAGE_W-1:0] pageIn,
  output logic [7:0]        byteOut,
  output logic [FILL_W-1:0] fillIdx,
  output logic              rowLast,
  output logic              fillLast,
  output logic              inRange
);

  localparam int ROW_BITS = ROW_BYTES * 8;

  logic [PAGE_W-1:0]   pageReg;
  logic [ROW_W-1:0]    rowIdx;
  logic [ROW_BITS-1:0] rowField;
  logic [7:0]          rowByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
    end else if (ctl.loadPage) begin
      pageReg <= pageIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowIdx  <= '0;
      fillIdx <= '0;
    end else if (ctl.clearIdx) begin
      rowIdx  <= '0;
      fillIdx <= '0;
    end else begin
      if (ctl.stepRow)  rowIdx  <= rowIdx + 1'b1;
      if (ctl.stepFill) fillIdx <= fillIdx + 1'b1;
    end
  end

  // page number widened or trimmed to the row field
  assign rowField = ROW_BITS'(pageReg);

  always_comb begin
    rowByte = 8'h00;
    for (int b = 0; b < ROW_BYTES; b++) begin
      if (rowIdx == ROW_W'(b)) rowByte = rowField[b*8 +: 8];
    end
  end

  assign rowLast  = (rowIdx == ROW_W'(ROW_BYTES - 1));
  assign fillLast = (fillIdx == FILL_W'(FILLS - 1));
  assign inRange  = (longint'(pageReg) <= PAGE_COUNT);

  always_comb begin
    unique case (ctl.byteSel)
      SEL_ROW:     byteOut = rowByte;
      SEL_RDSTART: byteOut = OP_READSTART;
      default:     byteOut = OP_READ0;
    endcase
  end

endmodule

// File: rtl/nand_rd_ctrl.sv
module nand_rd_ctrl
  import nand_rd_pkg::*;
#(
  parameter bit LARGE_PAGE = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      stepRdy,
  input  logic      rowLast,
  input  logic      fillLast,
  input  logic      inRange,
  output logic      busy,
  output logic      done,
  output logic      reqStrobe,
  output stepKind_e reqKind,
  output dpCtl_t    ctl
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FINISH} state_e;

  state_e state;
  phase_e phase;
  phase_e phaseNext;
  logic   ackNow;

  assign ackNow = (state == S_WAIT) && stepRdy;

  // step order; only consulted on an acknowledgement
  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_READ0:   phaseNext = PH_COL0;
      PH_COL0:    phaseNext = LARGE_PAGE ? PH_COL1 : (inRange ? PH_ROW : PH_TAIL);
      PH_COL1:    phaseNext = inRange ? PH_ROW : PH_TAIL;
      PH_ROW:     phaseNext = rowLast ? PH_TAIL : PH_ROW;
      PH_TAIL:    phaseNext = LARGE_PAGE ? PH_RDSTART : PH_FILL;
      PH_RDSTART: phaseNext = PH_FILL;
      PH_FILL:    phaseNext = PH_FILL;
      default:    phaseNext = PH_READ0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= PH_READ0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_ISSUE;
            phase <= PH_READ0;
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: begin
          if (stepRdy) begin
            if (phase == PH_FILL && fillLast) begin
              state <= S_FINISH;
            end else begin
              state <= S_ISSUE;
              phase <= phaseNext;
            end
          end
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FINISH);
  assign reqStrobe = (state == S_ISSUE);

  always_comb begin
    unique case (phase)
      PH_READ0, PH_RDSTART: reqKind = KIND_CMD;
      PH_FILL:              reqKind = KIND_FILL;
      default:              reqKind = KIND_ADDR;
    endcase
  end

  always_comb begin
    ctl.loadPage = (state == S_IDLE) && start;
    ctl.clearIdx = (state == S_IDLE) && start;
    ctl.stepRow  = ackNow && (phase == PH_ROW) && !rowLast;
    ctl.stepFill = ackNow && (phase == PH_FILL) && !fillLast;
    unique case (phase)
      PH_ROW:     ctl.byteSel = SEL_ROW;
      PH_RDSTART: ctl.byteSel = SEL_RDSTART;
      default:    ctl.byteSel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
  import nand_rd_pkg::*;
#(
  parameter int     PAGE_BYTES   = 2048,
  parameter longint DEVICE_BYTES = 134217728,
  localparam longint PAGE_COUNT  = DEVICE_BYTES / PAGE_BYTES,
  localparam int     ROW_BYTES   = rowBytesFor(PAGE_COUNT - 1),
  localparam int     ROW_W       = widthFor(ROW_BYTES),
  localparam int     FILLS       = PAGE_BYTES / CHUNK_BYTES,
  localparam int     FILL_W      = widthFor(FILLS),
  localparam int     PAGE_W      = $clog2(PAGE_COUNT) + 1,
  localparam bit     LARGE_PAGE  = (PAGE_BYTES > CHUNK_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PAGE_W-1:0] pageAddr,
  input  logic              stepRdy,
  output logic              busy,
  output logic              done,
  output logic              reqStrobe,
  output logic [1:0]        reqKind,
  output logic [7:0]        reqByte,
  output logic [FILL_W-1:0] bufIdx
);

  dpCtl_t    ctlBus;
  stepKind_e kindInt;
  logic      rowLast;
  logic      fillLast;
  logic      inRange;

  nand_rd_ctrl #(
    .LARGE_PAGE(LARGE_PAGE)
  ) ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .stepRdy  (stepRdy),
    .rowLast  (rowLast),
    .fillLast (fillLast),
    .inRange  (inRange),
    .busy     (busy),
    .done     (done),
    .reqStrobe(reqStrobe),
    .reqKind  (kindInt),
    .ctl      (ctlBus)
  );

  nand_rd_dpath #(
    .PAGE_W    (PAGE_W),
    .ROW_BYTES (ROW_BYTES),
    .ROW_W     (ROW_W),
    .FILLS     (FILLS),
    .FILL_W    (FILL_W),
    .PAGE_COUNT(PAGE_COUNT)
  ) dpathI (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctlBus),
    .pageIn  (pageAddr),
    .byteOut (reqByte),
    .fillIdx (bufIdx),
    .rowLast (rowLast),
    .fillLast(fillLast),
    .inRange (inRange)
  );

  assign reqKind = kindInt;

endmodule

// File: rtl/nand_rd_seq_chk.sv
module nand_rd_seq_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             stepRdy,
  input logic             busy,
  input logic             done,
  input logic             reqStrobe,
  input logic [1:0]       reqKind,
  input logic [7:0]       reqByte,
  input logic [IDX_W-1:0] bufIdx
);

  assert_busy_after_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_ends_on_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqStrobe |=> !reqStrobe);

  assert_strobe_in_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqStrobe |-> busy);

  assert_step_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !reqStrobe && !done)
      |-> ($stable(reqKind) && $stable(reqByte) && $stable(bufIdx)));

  assert_first_read0_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (reqStrobe && reqKind == 2'd0 && reqByte == 8'h00));

  assert_done_after_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(stepRdy) && reqKind == 2'd2));

endmodule

bind nand_rd_seq nand_rd_seq_chk #(.IDX_W(FILL_W)) chkI (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .stepRdy  (stepRdy),
  .busy     (busy),
  .done     (done),
  .reqStrobe(reqStrobe),
  .reqKind  (reqKind),
  .reqByte  (reqByte),
  .bufIdx   (bufIdx)
);

// File: tb/nand_rd_seq_test.sv
module nand_rd_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [16:0] pageA = '0;
  logic [14:0] pageB = '0;
  logic        rdyResp [2];
  logic        rdyStray = 1'b0;

  logic        busyV   [2];
  logic        doneV   [2];
  logic        strobeV [2];
  logic [1:0]  kindV   [2];
  logic [7:0]  byteV   [2];
  logic [1:0]  idxV    [2];
  logic [1:0]  idxA;
  logic [0:0]  idxB;

  int total = 0;
  int bad = 0;
  int respDelay = 1;
  bit echoStray = 1'b0;

  logic [1:0] kLog [2][32];
  logic [7:0] bLog [2][32];
  logic [1:0] iLog [2][32];
  int nLog [2];
  int nDone [2];
  int busyGap [2];

  logic [1:0] eK [32];
  logic [7:0] eB [32];
  logic [1:0] eI [32];
  string      eT [32];
  int         eN;

  always #10 clk = ~clk;

  initial begin
    rdyResp[0] = 1'b0;
    rdyResp[1] = 1'b0;
  end

  nand_rd_seq uut (
    .clk(clk), .rstN(rstN), .start(start), .pageAddr(pageA),
    .stepRdy(rdyResp[0] | rdyStray), .busy(busyV[0]), .done(doneV[0]),
    .reqStrobe(strobeV[0]), .reqKind(kindV[0]), .reqByte(byteV[0]), .bufIdx(idxA)
  );

  nand_rd_seq #(.PAGE_BYTES(512), .DEVICE_BYTES(8388608)) uutSmall (
    .clk(clk), .rstN(rstN), .start(start), .pageAddr(pageB),
    .stepRdy(rdyResp[1] | rdyStray), .busy(busyV[1]), .done(doneV[1]),
    .reqStrobe(strobeV[1]), .reqKind(kindV[1]), .reqByte(byteV[1]), .bufIdx(idxB)
  );

  always_comb begin
    idxV[0] = idxA;
    idxV[1] = {1'b0, idxB};
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // flash engine model: logs each step, acknowledges after a delay
  task automatic respond(input int inst);
    forever begin
      if (strobeV[inst] === 1'b1) begin
        if (nLog[inst] < 32) begin
          kLog[inst][nLog[inst]] = kindV[inst];
          bLog[inst][nLog[inst]] = byteV[inst];
          iLog[inst][nLog[inst]] = idxV[inst];
        end
        nLog[inst]++;
        if (echoStray) begin
          rdyResp[inst] = 1'b1;
          @(negedge clk);
          rdyResp[inst] = 1'b0;
        end
        repeat (respDelay) @(negedge clk);
        rdyResp[inst] = 1'b1;
        @(negedge clk);
        rdyResp[inst] = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial respond(0);
  initial respond(1);

  logic prevBusy [2];
  logic prevDone [2];
  initial begin
    prevBusy[0] = 1'b0; prevBusy[1] = 1'b0;
    prevDone[0] = 1'b0; prevDone[1] = 1'b0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        if (doneV[i] === 1'b1) begin
          nDone[i]++;
          if (busyV[i] !== 1'b1) busyGap[i]++;
        end
        if (prevBusy[i] === 1'b1 && busyV[i] === 1'b0 && prevDone[i] !== 1'b1) busyGap[i]++;
        prevBusy[i] = busyV[i];
        prevDone[i] = doneV[i];
      end
    end
  end

  task automatic addStep(input logic [1:0] k, input logic [7:0] b,
                         input logic [1:0] ix, input string tag);
    eK[eN] = k; eB[eN] = b; eI[eN] = ix; eT[eN] = tag;
    eN++;
  endtask

  // expected step list built from the requirements
  task automatic buildExpect(input int inst, input longint page);
    longint pageBytes = (inst == 0) ? 2048 : 512;
    longint pageCount = (inst == 0) ? 65536 : 16384;
    longint last;
    longint p;
    eN = 0;
    addStep(2'd0, 8'h00, 2'd0, "R3");
    addStep(2'd1, 8'h00, 2'd0, "R4");
    if (pageBytes > 512) addStep(2'd1, 8'h00, 2'd0, "R4");
    if (page <= pageCount) begin
      last = pageCount - 1;
      p = page;
      do begin
        addStep(2'd1, 8'(p & 255), 2'd0, "R5");
        p = p >> 8;
        last = last >> 8;
      end while (last != 0);
    end
    addStep(2'd1, 8'h00, 2'd0, "R7");
    if (pageBytes > 512) addStep(2'd0, 8'h30, 2'd0, "R8");
    for (int c = 0; c < pageBytes / 512; c++) addStep(2'd2, 8'h00, 2'(c), "R9");
  endtask

  task automatic runRead(input longint pA, input longint pB, input int dly,
                         input bit echo, input bit poke);
    int t;
    longint pg;
    for (int i = 0; i < 2; i++) begin
      nLog[i] = 0; nDone[i] = 0; busyGap[i] = 0;
    end
    respDelay = dly;
    echoStray = echo;
    @(negedge clk);
    start = 1'b1; pageA = 17'(pA); pageB = 15'(pB);
    @(negedge clk);
    start = 1'b0;
    check(busyV[0] === 1'b1 && busyV[1] === 1'b1, "R1", "busy after start",
          {busyV[0], busyV[1]}, 3);
    if (poke) begin
      repeat (2) @(negedge clk);
      start = 1'b1; pageA = 17'(pA ^ 3); pageB = 15'(pB ^ 3);
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while ((busyV[0] === 1'b1 || busyV[1] === 1'b1) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(t < 5000, "R9", "run completes", t, 0);
    for (int i = 0; i < 2; i++) begin
      pg = (i == 0) ? pA : pB;
      buildExpect(i, pg);
      check(nLog[i] == eN, (pg > ((i == 0) ? 65536 : 16384)) ? "R6" : "R5",
            $sformatf("inst%0d page%0d step count", i, pg), nLog[i], eN);
      for (int s = 0; s < eN && s < nLog[i]; s++) begin
        check(kLog[i][s] == eK[s], "R3", $sformatf("inst%0d step%0d kind", i, s),
              kLog[i][s], eK[s]);
        if (eK[s] != 2'd2)
          check(bLog[i][s] == eB[s], eT[s], $sformatf("inst%0d step%0d byte", i, s),
                bLog[i][s], eB[s]);
        else
          check(iLog[i][s] == eI[s], "R9", $sformatf("inst%0d step%0d bufIdx", i, s),
                iLog[i][s], eI[s]);
      end
      check(nDone[i] == 1, "R9", $sformatf("inst%0d done pulses", i), nDone[i], 1);
      check(busyGap[i] == 0, "R1", $sformatf("inst%0d busy/done framing", i), busyGap[i], 0);
    end
  endtask

  task automatic testResetState;
    for (int i = 0; i < 2; i++) begin
      check(busyV[i] === 1'b0 && doneV[i] === 1'b0 && strobeV[i] === 1'b0, "R1",
            $sformatf("inst%0d reset outputs", i),
            {busyV[i], doneV[i], strobeV[i]}, 0);
    end
  endtask

  task automatic testNormal;
    runRead(64'h1234, 64'h0ABC, 1, 1'b0, 1'b0);
  endtask

  task automatic testPageLimit;
    runRead(65536, 16384, 3, 1'b0, 1'b0);
    runRead(65535, 16383, 2, 1'b0, 1'b0);
  endtask

  task automatic testOutOfRange;
    runRead(65537, 16385, 1, 1'b0, 1'b0);
  endtask

  task automatic testStrayAtStrobe;
    // R2: ready coinciding with a strobe must not retire the step
    runRead(64'h00A5, 64'h005A, 2, 1'b1, 1'b0);
  endtask

  task automatic testStartWhileBusy;
    // R1: second start inside a run leaves the captured page in force
    runRead(64'h4321, 64'h1357, 2, 1'b0, 1'b1);
  endtask

  task automatic testStrayIdle;
    int seen = 0;
    @(negedge clk);
    rdyStray = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++)
        if (strobeV[i] !== 1'b0 || busyV[i] !== 1'b0 || doneV[i] !== 1'b0) seen++;
    end
    rdyStray = 1'b0;
    @(negedge clk);
    check(seen == 0, "R2", "stray ready while idle", seen, 0);
    runRead(64'h0001, 64'h0002, 1, 1'b0, 1'b0);
  endtask

  task automatic testBackToBack;
    runRead(64'hFF00, 64'h3F00, 1, 1'b0, 1'b0);
    runRead(64'h00FF, 64'h00FF, 1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    nLog[0] = 0; nLog[1] = 0;
    nDone[0] = 0; nDone[1] = 0;
    busyGap[0] = 0; busyGap[1] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testNormal();
    testPageLimit();
    testOutOfRange();
    testStrayAtStrobe();
    testStartWhileBusy();
    testStrayIdle();
    testBackToBack();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule